// File: doc/BRIEF.md
# Serial Flow-Control Status Unit

This unit keeps a 32-bit control and status word for an asynchronous serial port and turns it into the port's flow-control and modem-line behaviour. The low byte holds writable policy bits. Bits 16 to 23 hold live status: received and sent flow-stop state, the four synchronised modem input levels, and the receive-buffer threshold flag. The remaining bytes are reserved. They hold their value, and the same masking that writes the policy byte can write them.

Software changes the word with one atomic operation. It supplies an AND mask and an XOR mask. On the next cycle the unit returns the word as it was before the operation and the word that resulted. The unit synchronises the CTS, DSR, DCD and RI lines, drives RTS and DTR, and removes XON (0x11) and XOFF (0x13) characters from the receive stream when in-band flow control is on. It queues its own XON or XOFF character for the transmitter, and gives that character priority over data. It also produces a transmit-permit level, a receive-accept strobe and a serial-event pulse.

Top module: `serial_flow_ctl`

## Requirements
- R1: When upd_valid is high at a clock edge, the stored word becomes (old AND upd_and) XOR upd_xor. On the following cycle upd_prev shows the whole word before the operation and upd_result shows the whole word after it.
- R2: An update never changes bits 16..23. Bits 0..15 and 24..31 follow the formula in R1.
- R3: After reset, every stored bit is 0. DTR is asserted (dtr_out=1), tx_permit=1, and rx_accept, serial_evt and tx_flow_valid are all 0.
- R4: Policy bit 7=1 forces rts_out=1. Otherwise, when bit 0=1, rts_out=1. When bit 0=0 and bit 5=1, rts_out=0. When bit 0=0 and bit 5=0, rts_out is the inverse of rx_buf_low.
- R5: dtr_out is the inverse of policy bit 3.
- R6: tx_permit is 0 in any of these cases: CTS is high and bit 4 is 0; DSR is high and bit 2 is 0; bit 0 is 1 and status bit 16 is set; a flow character is pending.
- R7: With bit 0=1, a received 0x13 sets status bit 16 and a received 0x11 clears it. Neither character is accepted into the buffer. With bit 0=0, both characters pass through as data.
- R8: With bit 0=1, a rise of rx_buf_low queues 0x13 and sets bit 17. A fall queues 0x11 and clears bits 17 and 22. tx_flow_valid stays high until a cycle in which tx_flow_ready is high.
- R9: With bit 0=1, a user_xoff pulse queues 0x13 and sets bits 17 and 22. A user_xon pulse queues 0x11 and clears both bits.
- R10: With bit 1=0, a rise of the synchronised DCD pulses serial_evt one cycle later. A character that arrives while DCD is high pulses serial_evt and is not accepted. With bit 1=1, DCD has no effect on events or acceptance.
- R11: With policy bit 6=1, no received character raises rx_accept.
- R12: Status bits 18, 19, 20 and 21 show DCD, DSR, RI and CTS, two clock edges after the line changes. Bit 23 follows rx_buf_low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Apply a masked update this cycle |
| upd_and | input | 32 | AND mask |
| upd_xor | input | 32 | XOR mask |
| upd_prev | output | 32 | Word before the last update |
| upd_result | output | 32 | Word after the last update |
| ctl_word | output | 32 | Live control and status word |
| cts_line | input | 1 | CTS line level, 1 = not clear |
| dsr_line | input | 1 | DSR line level, 1 = not ready |
| dcd_line | input | 1 | DCD line level, 1 = no carrier |
| ri_line | input | 1 | Ring indicator level |
| rts_out | output | 1 | RTS level |
| dtr_out | output | 1 | DTR asserted |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | CHAR_W | Received character |
| rx_accept | output | 1 | Character goes into the buffer (one cycle later) |
| rx_data_out | output | CHAR_W | Accepted character |
| rx_buf_low | input | 1 | Buffer free space below threshold |
| user_xoff | input | 1 | Request to send a stop character |
| user_xon | input | 1 | Request to send a resume character |
| tx_permit | output | 1 | Data transmission allowed |
| tx_flow_valid | output | 1 | Flow character pending |
| tx_flow_char | output | CHAR_W | Flow character to send |
| tx_flow_ready | input | 1 | Transmitter takes the flow character |
| serial_evt | output | 1 | Serial event pulse |

## Verification
The hardest case to reach from the ports is a flow character that is still pending while a line gate or a received stop also holds tx_permit low. That state needs in-band mode, a threshold edge and a transmitter that is not ready, all held at the same time. Directed sequences build it step by step by holding tx_flow_ready low across several cycles. The randomized phase mixes random mask pairs with random modem levels, waits out the synchroniser between them, and compares the old and new words and the line outputs against a model of the word.

// File: rtl/flc_pkg.sv
package flc_pkg;
   localparam int WORD_W    = 32;
   localparam int P_XMODE   = 0;
   localparam int P_DCD_IGN = 1;
   localparam int P_DSR_IGN = 2;
   localparam int P_DTR_OFF = 3;
   localparam int P_CTS_IGN = 4;
   localparam int P_RTS_OFF = 5;
   localparam int P_RX_MUTE = 6;
   localparam int P_RTS_HI  = 7;
   localparam int STAT_LSB  = 16;
   localparam logic [WORD_W-1:0] WR_MASK = 32'hFF00_FFFF;

   // msb maps to word bit 23, lsb to bit 16
   typedef struct packed {
      logic buf_low;
      logic man_xoff;
      logic cts;
      logic ri;
      logic dsr;
      logic dcd;
      logic xoff_sent;
      logic xoff_rx;
   } stat_t;
endpackage

// File: rtl/flc_line_sync.sv
module flc_line_sync #(
   parameter int LINES  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] d,
   output logic [LINES-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("flc_line_sync needs at least two stages");
   end

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-2:0], d[l]};
      end
      assign q[l] = sh[STAGES-1];
   end
endmodule

// File: rtl/flc_xon_engine.sv
module flc_xon_engine #(
   parameter int                CHAR_W    = 8,
   parameter logic [CHAR_W-1:0] XON_CODE  = 8'h11,
   parameter logic [CHAR_W-1:0] XOFF_CODE = 8'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xmode,
   input  logic              rx_hit,
   input  logic [CHAR_W-1:0] rx_char,
   input  logic              buf_low,
   input  logic              usr_xoff,
   input  logic              usr_xon,
   input  logic              flow_ready,
   output logic              is_flow,
   output logic              xoff_rx,
   output logic              xoff_sent,
   output logic              man_xoff,
   output logic              flow_valid,
   output logic [CHAR_W-1:0] flow_char
);
   if (XON_CODE == XOFF_CODE) begin : g_bad_codes
      $error("flc_xon_engine resume and stop codes must differ");
   end

   logic buf_prev;
   logic buf_rise, buf_fall;

   assign buf_rise = buf_low && !buf_prev;
   assign buf_fall = !buf_low && buf_prev;
   assign is_flow  = xmode && (rx_char == XON_CODE || rx_char == XOFF_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_prev   <= 1'b0;
         xoff_rx    <= 1'b0;
         xoff_sent  <= 1'b0;
         man_xoff   <= 1'b0;
         flow_valid <= 1'b0;
         flow_char  <= '0;
      end else begin
         buf_prev <= buf_low;
         if (rx_hit && xmode) begin
            if (rx_char == XOFF_CODE)     xoff_rx <= 1'b1;
            else if (rx_char == XON_CODE) xoff_rx <= 1'b0;
         end
         if (flow_valid && flow_ready) flow_valid <= 1'b0;
         if (xmode) begin
            if (buf_rise) begin
               flow_valid <= 1'b1;
               flow_char  <= XOFF_CODE;
               xoff_sent  <= 1'b1;
            end else if (buf_fall) begin
               flow_valid <= 1'b1;
               flow_char  <= XON_CODE;
               xoff_sent  <= 1'b0;
               man_xoff   <= 1'b0;
            end else if (usr_xoff) begin
               flow_valid <= 1'b1;
               flow_char  <= XOFF_CODE;
               xoff_sent  <= 1'b1;
               man_xoff   <= 1'b1;
            end else if (usr_xon) begin
               flow_valid <= 1'b1;
               flow_char  <= XON_CODE;
               xoff_sent  <= 1'b0;
               man_xoff   <= 1'b0;
            end
         end
      end
   end

   // R8
   flow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flow_valid && !flow_ready |=> flow_valid);

   // R8
   stop_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_low) && xmode |=> flow_valid && flow_char == XOFF_CODE && xoff_sent);

   // R7
   stop_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hit && xmode && rx_char == XOFF_CODE |=> xoff_rx);
endmodule

// File: rtl/serial_flow_ctl.sv
module serial_flow_ctl
   import flc_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                CHAR_W      = 8,
   parameter logic [CHAR_W-1:0] XON_CODE    = 8'h11,
   parameter logic [CHAR_W-1:0] XOFF_CODE   = 8'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   input  logic [31:0]       upd_and,
   input  logic [31:0]       upd_xor,
   output logic [31:0]       upd_prev,
   output logic [31:0]       upd_result,
   output logic [31:0]       ctl_word,
   input  logic              cts_line,
   input  logic              dsr_line,
   input  logic              dcd_line,
   input  logic              ri_line,
   output logic              rts_out,
   output logic              dtr_out,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_char,
   output logic              rx_accept,
   output logic [CHAR_W-1:0] rx_data_out,
   input  logic              rx_buf_low,
   input  logic              user_xoff,
   input  logic              user_xon,
   output logic              tx_permit,
   output logic              tx_flow_valid,
   output logic [CHAR_W-1:0] tx_flow_char,
   input  logic              tx_flow_ready,
   output logic              serial_evt
);
   localparam int NLINES = 4;

   logic [WORD_W-1:0] stored;
   logic [WORD_W-1:0] upd_calc;
   logic [NLINES-1:0] lines_s;
   logic              cts_s, dsr_s, dcd_s, ri_s;
   logic              dcd_prev;
   logic              dcd_block, rx_ok, is_flow;
   logic              xoff_rx, xoff_sent, man_xoff;
   stat_t             stat;

   flc_line_sync #(.LINES(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d ({ri_line, dsr_line, dcd_line, cts_line}),
      .q (lines_s)
   );
   assign {ri_s, dsr_s, dcd_s, cts_s} = lines_s;

   assign dcd_block = !stored[P_DCD_IGN] && dcd_s;
   assign rx_ok     = rx_valid && !dcd_block;

   flc_xon_engine #(.CHAR_W(CHAR_W), .XON_CODE(XON_CODE), .XOFF_CODE(XOFF_CODE)) u_xon (
      .clk        (clk),
      .rst_n      (rst_n),
      .xmode      (stored[P_XMODE]),
      .rx_hit     (rx_ok),
      .rx_char    (rx_char),
      .buf_low    (rx_buf_low),
      .usr_xoff   (user_xoff),
      .usr_xon    (user_xon),
      .flow_ready (tx_flow_ready),
      .is_flow    (is_flow),
      .xoff_rx    (xoff_rx),
      .xoff_sent  (xoff_sent),
      .man_xoff   (man_xoff),
      .flow_valid (tx_flow_valid),
      .flow_char  (tx_flow_char)
   );

   always_comb begin
      stat.buf_low   = rx_buf_low;
      stat.man_xoff  = man_xoff;
      stat.cts       = cts_s;
      stat.ri        = ri_s;
      stat.dsr       = dsr_s;
      stat.dcd       = dcd_s;
      stat.xoff_sent = xoff_sent;
      stat.xoff_rx   = xoff_rx;
   end

   assign ctl_word = stored | {8'h00, stat, 16'h0000};
   assign upd_calc = ((ctl_word & upd_and) ^ upd_xor) & WR_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stored     <= '0;
         upd_prev   <= '0;
         upd_result <= '0;
      end else if (upd_valid) begin
         stored     <= upd_calc;
         upd_prev   <= ctl_word;
         upd_result <= upd_calc | (ctl_word & ~WR_MASK);
      end
   end

   always_comb begin
      if (stored[P_RTS_HI])      rts_out = 1'b1;
      else if (stored[P_XMODE])  rts_out = 1'b1;
      else if (stored[P_RTS_OFF]) rts_out = 1'b0;
      else                       rts_out = !rx_buf_low;
   end

   assign dtr_out   = !stored[P_DTR_OFF];
   assign tx_permit = !tx_flow_valid
                    && !(cts_s && !stored[P_CTS_IGN])
                    && !(dsr_s && !stored[P_DSR_IGN])
                    && !(xoff_rx && stored[P_XMODE]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dcd_prev    <= 1'b0;
         rx_accept   <= 1'b0;
         rx_data_out <= '0;
         serial_evt  <= 1'b0;
      end else begin
         dcd_prev    <= dcd_s;
         rx_accept   <= rx_ok && !is_flow && !stored[P_RX_MUTE];
         if (rx_valid) rx_data_out <= rx_char;
         serial_evt  <= (!stored[P_DCD_IGN] && dcd_s && !dcd_prev)
                      || (rx_valid && dcd_block);
      end
   end

   // R11
   mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_accept |-> !$past(stored[P_RX_MUTE]));

   // R10
   carrier_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && dcd_s && !stored[P_DCD_IGN] |=> serial_evt && !rx_accept);

   // R2
   stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> (stored[23:16] == 8'h00));
endmodule

// File: tb/test_serial_flow_ctl.sv
`timescale 1ns/1ps
module test_serial_flow_ctl;
   localparam logic [31:0] WRM = 32'hFF00_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_and = '0, upd_xor = '0;
   logic [31:0] upd_prev, upd_result, ctl_word;
   logic        cts_line = 0, dsr_line = 0, dcd_line = 0, ri_line = 0;
   logic        rts_out, dtr_out;
   logic        rx_valid = 0;
   logic [7:0]  rx_char = '0;
   logic        rx_accept;
   logic [7:0]  rx_data_out;
   logic        rx_buf_low = 0, user_xoff = 0, user_xon = 0;
   logic        tx_permit, tx_flow_valid, tx_flow_ready = 0, serial_evt;
   logic [7:0]  tx_flow_char;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [31:0] m_store = '0;

   always #2.5 clk = ~clk;

   serial_flow_ctl i_serial_flow_ctl (.*);

   task automatic tick(); @(negedge clk); endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic f_rts(logic [31:0] w, logic low);
      if (w[7]) return 1'b1;
      if (w[0]) return 1'b1;
      if (w[5]) return 1'b0;
      return !low;
   endfunction

   function automatic logic f_permit(logic [31:0] w, logic cts, logic dsr, logic xrx, logic pend);
      return !pend && !(cts && !w[4]) && !(dsr && !w[2]) && !(xrx && w[0]);
   endfunction

   task automatic set_word(input logic [31:0] v);
      upd_and = '0; upd_xor = v; upd_valid = 1;
      tick();
      upd_valid = 0;
      m_store = v & WRM;
   endtask

   task automatic send_rx(input logic [7:0] c);
      rx_char = c; rx_valid = 1;
      tick();
      rx_valid = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] full, expres;
      void'($urandom(32'h5EED_1234));
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R3 reset state
      chk(ctl_word == 0, "R3 word", ctl_word, 0);
      chk(dtr_out == 1 && tx_permit == 1, "R3 dtr/permit", {dtr_out, tx_permit}, 2'b11);
      chk(!rx_accept && !serial_evt && !tx_flow_valid, "R3 strobes",
          {rx_accept, serial_evt, tx_flow_valid}, 0);

      // random masks and modem levels: R1 R2 R4 R5 R6 R12
      for (int i = 0; i < 200; i++) begin
         logic [3:0] ln;
         ln = 4'($urandom);
         {ri_line, cts_line, dsr_line, dcd_line} = ln;
         repeat (3) tick();
         full = m_store | {8'h00, 2'b00, cts_line, ri_line, dsr_line, dcd_line, 2'b00, 16'h0};
         chk(ctl_word == full, "R12 status levels", ctl_word, full);
         upd_and = $urandom; upd_xor = $urandom; upd_valid = 1;
         tick();
         upd_valid = 0;
         expres = (((full & upd_and) ^ upd_xor) & WRM) | (full & ~WRM);
         chk(upd_prev == full, "R1 old word", upd_prev, full);
         chk(upd_result == expres, "R1 R2 new word", upd_result, expres);
         m_store = expres & WRM;
         chk(rts_out == f_rts(m_store, 1'b0), "R4 rts", rts_out, f_rts(m_store, 1'b0));
         chk(dtr_out == !m_store[3], "R5 dtr", dtr_out, !m_store[3]);
         chk(tx_permit == f_permit(m_store, cts_line, dsr_line, 1'b0, 1'b0), "R6 permit",
             tx_permit, f_permit(m_store, cts_line, dsr_line, 1'b0, 1'b0));
      end
      {ri_line, cts_line, dsr_line, dcd_line} = 4'h0;
      repeat (3) tick();

      // R7 in-band receive
      set_word(32'h1);
      send_rx(8'h13);
      chk(!rx_accept, "R7 stop not stored", rx_accept, 0);
      chk(ctl_word[16] && !tx_permit, "R7 stop halts", {ctl_word[16], tx_permit}, 2'b10);
      send_rx(8'h41);
      chk(rx_accept && rx_data_out == 8'h41, "R7 data passes", {rx_accept, rx_data_out}, {1'b1, 8'h41});
      send_rx(8'h11);
      chk(!rx_accept && !ctl_word[16] && tx_permit, "R7 resume",
          {rx_accept, ctl_word[16], tx_permit}, 3'b001);
      set_word(32'h0);
      send_rx(8'h13);
      chk(rx_accept && !ctl_word[16], "R7 mode off passes", {rx_accept, ctl_word[16]}, 2'b10);

      // R8 threshold-driven flow characters
      set_word(32'h1);
      rx_buf_low = 1;
      tick();
      chk(tx_flow_valid && tx_flow_char == 8'h13, "R8 stop queued", {tx_flow_valid, tx_flow_char}, {1'b1, 8'h13});
      chk(ctl_word[17] && ctl_word[23] && !tx_permit, "R8 bits/permit",
          {ctl_word[17], ctl_word[23], tx_permit}, 3'b110);
      chk(rts_out == 1, "R4 rts in-band mode", rts_out, 1);
      tick();
      chk(tx_flow_valid, "R8 held while not ready", tx_flow_valid, 1);
      tx_flow_ready = 1;
      tick();
      tx_flow_ready = 0;
      chk(!tx_flow_valid && tx_permit, "R8 taken", {tx_flow_valid, tx_permit}, 2'b01);
      rx_buf_low = 0;
      tick();
      chk(tx_flow_valid && tx_flow_char == 8'h11 && !ctl_word[17], "R8 resume queued",
          {tx_flow_valid, tx_flow_char, ctl_word[17]}, {1'b1, 8'h11, 1'b0});
      tx_flow_ready = 1; tick(); tx_flow_ready = 0;

      // R9 user requests
      user_xoff = 1; tick(); user_xoff = 0;
      chk(tx_flow_valid && tx_flow_char == 8'h13 && ctl_word[22] && ctl_word[17], "R9 user stop",
          {tx_flow_valid, tx_flow_char, ctl_word[22], ctl_word[17]}, {1'b1, 8'h13, 2'b11});
      tx_flow_ready = 1; tick(); tx_flow_ready = 0;
      user_xon = 1; tick(); user_xon = 0;
      chk(tx_flow_char == 8'h11 && !ctl_word[22] && !ctl_word[17], "R9 user resume",
          {tx_flow_char, ctl_word[22], ctl_word[17]}, {8'h11, 2'b00});
      tx_flow_ready = 1; tick(); tx_flow_ready = 0;

      // R4 hardware handshake
      set_word(32'h0);
      rx_buf_low = 1; tick();
      chk(rts_out == 0, "R4 rts low when buffer low", rts_out, 0);
      rx_buf_low = 0; tick();
      chk(rts_out == 1, "R4 rts high with room", rts_out, 1);
      set_word(32'h20);
      chk(rts_out == 0, "R4 rts off", rts_out, 0);
      set_word(32'hA0);
      chk(rts_out == 1, "R4 rts forced", rts_out, 1);

      // R10 carrier
      set_word(32'h0);
      dcd_line = 1;
      repeat (3) tick();
      chk(serial_evt && ctl_word[18], "R10 carrier loss event", {serial_evt, ctl_word[18]}, 2'b11);
      tick();
      chk(!serial_evt, "R10 single pulse", serial_evt, 0);
      send_rx(8'h55);
      chk(serial_evt && !rx_accept, "R10 discard", {serial_evt, rx_accept}, 2'b10);
      set_word(32'h2);
      send_rx(8'h56);
      chk(!serial_evt && rx_accept, "R10 ignored", {serial_evt, rx_accept}, 2'b01);
      dcd_line = 0; repeat (3) tick();

      // R11 suppression
      set_word(32'h40);
      send_rx(8'h42);
      chk(!rx_accept, "R11 muted", rx_accept, 0);

      // R6 directed DSR gating
      set_word(32'h0);
      dsr_line = 1; repeat (3) tick();
      chk(!tx_permit, "R6 dsr blocks", tx_permit, 0);
      set_word(32'h4);
      chk(tx_permit, "R6 dsr ignored", tx_permit, 1);
      dsr_line = 0;

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule